// File: doc/BRIEF.md
# Serial EEPROM Page-Write Engine

This block is the write half of a serial-bus EEPROM slave with a 512-byte array. It oversamples chip select, serial clock, serial data and the write-protect pin on a fast system clock. It assembles bytes most significant bit first and decodes a write-enable instruction and a page-write instruction. The page-write instruction carries the ninth address bit inside its opcode. Data bytes are collected in a page buffer. Consecutive bytes advance through the page and wrap back to the page start once its last byte has been passed.

When chip select is released exactly on a byte boundary, after at least one data byte and with every permission in place, the block starts a timed write cycle and raises its busy flag. During the first clocks of that cycle it copies every buffered byte, one per clock, onto a synchronous memory write port. At the end of the cycle it drops the busy flag and the enable latch. An instruction that is refused or malformed leaves the memory port silent.

Top module: `spiw_write_engine`

## Requirements
- R1: After reset the enable latch (`wel`) and busy flag (`wip`) are 0 and `mem_we` is 0.
- R2: The byte 0x06 followed by a deselect after exactly eight bits sets `wel` while no write cycle runs. A deselect at any other bit count leaves `wel` unchanged.
- R3: Bits are taken on rising serial-clock edges, MSB first. A write instruction is opcode `0000_A010`, then the low address byte, then data bytes. A single accepted data byte appears once on the memory port at its address.
- R4: Opcode bit 3 (A) is address bit 8.
- R5: Pages are 16 bytes, with page = addr[8:4] and offset = addr[3:0]. Each further data byte goes to the next offset, wrapping from 15 to 0 in the same page. When an offset is written twice, the later byte is stored.
- R6: A write instruction issued while `wel` is 0 produces no memory write and no write cycle.
- R7: A write is aborted, with no memory write, if the deselect falls between byte boundaries or comes before any data byte.
- R8: A write is refused when `wp_n` is 0 at deselect, or when `bp` protects its page. The `bp` encoding is 00 none, 01 addresses 0x180-0x1FF, 10 addresses 0x100-0x1FF, 11 all.
- R9: An accepted write holds `wip` at 1 for `TWR_CYCLES` system clocks after the deselect is seen. Memory writes occur only while `wip` is 1, at most one per clock, all in the addressed page, one per written offset.
- R10: `wel` returns to 0 when a write cycle ends, and whenever a write instruction is not executed.
- R11: Any instruction that starts while `wip` is 1 is ignored. It does not touch the buffer, the memory port or `wel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling and the write timer |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Write protect, active low |
| bp | input | 2 | Block-protect level |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write cycle in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 9 | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
A wrong bit count or boundary flag shows up within the three-clock synchronizer delay after deselect, as `wip` rising when it should not, or staying low when it should rise. A corrupted buffer offset or page register only becomes visible during the commit burst, as bytes landing at the wrong addresses of the page. A timer fault shows at the end of the cycle, when `wip` falls early or late. The sweeps therefore compare whole pages and the `wip` edges at fixed clock distances from the deselect.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
    localparam int ADDR_W = 9;
    localparam logic [7:0] OP_WREN = 8'h06;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPC, PH_ADR, PH_DATA, PH_WREN, PH_SKIP
    } phase_e;

    function automatic logic is_write_op(input logic [7:0] b);
        return (b[7:4] == 4'h0) && (b[2:0] == 3'b010);
    endfunction
endpackage

// File: rtl/spiw_shift.sv
module spiw_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic       wp_n,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       byte_stb,
    output logic [7:0] byte_val,
    output logic [2:0] bit_cnt,
    output logic       wp_ok
);
    // sync vector bit order: 0 cs_n, 1 sclk, 2 mosi, 3 wp_n
    localparam logic [3:0] SYNC_RST = 4'b1001;

    typedef struct packed {
        logic [3:0] s1;
        logic [3:0] s2;
        logic [3:0] s3;
        logic [6:0] sh;
        logic [2:0] bcnt;
    } sh_st_t;

    sh_st_t q, d;
    logic   sck_rise;

    always_comb begin
        d        = q;
        d.s1     = {wp_n, mosi, sclk, cs_n};
        d.s2     = q.s1;
        d.s3     = q.s2;
        cs_fall  = q.s3[0] & ~q.s2[0];
        cs_rise  = ~q.s3[0] & q.s2[0];
        sck_rise = ~q.s3[1] & q.s2[1] & ~q.s2[0];
        byte_stb = 1'b0;
        byte_val = {q.sh, q.s2[2]};
        if (cs_fall) begin
            d.bcnt = '0;
        end else if (sck_rise) begin
            d.sh     = {q.sh[5:0], q.s2[2]};
            d.bcnt   = q.bcnt + 3'd1;
            byte_stb = (q.bcnt == 3'd7);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1   <= SYNC_RST;
            q.s2   <= SYNC_RST;
            q.s3   <= SYNC_RST;
            q.sh   <= '0;
            q.bcnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign bit_cnt = q.bcnt;
    assign wp_ok   = q.s2[3];

    a_r3_byte_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> !q.s2[0]);
endmodule

// File: rtl/spiw_pagebuf.sv
module spiw_pagebuf #(
    parameter int DEPTH = 16,
    localparam int OFF_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    input  logic [OFF_W-1:0] rd_off,
    output logic [7:0]       rd_data,
    output logic             rd_valid
);
    logic [7:0]       data_q [DEPTH];
    logic [7:0]       data_d [DEPTH];
    logic [DEPTH-1:0] vld_q, vld_d;

    always_comb begin
        vld_d = clr ? '0 : vld_q;
        for (int i = 0; i < DEPTH; i++) begin
            data_d[i] = data_q[i];
        end
        if (wr) begin
            data_d[wr_off] = wr_data;
            vld_d[wr_off]  = 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) data_q[g] <= '0;
                else        data_q[g] <= data_d[g];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    assign rd_data  = data_q[rd_off];
    assign rd_valid = vld_q[rd_off];

    a_r5_written_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> vld_q[$past(wr_off)]);
endmodule

// File: rtl/spiw_prot.sv
module spiw_prot #(
    parameter int PAGE_W = 5
) (
    input  logic [1:0]        bp,
    input  logic [PAGE_W-1:0] page,
    output logic              hit
);
    always_comb begin
        unique case (bp)
            2'b00: hit = 1'b0;
            2'b01: hit = &page[PAGE_W-1 -: 2];
            2'b10: hit = page[PAGE_W-1];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/spiw_write_engine.sv
module spiw_write_engine #(
    parameter int PAGE_BYTES = 16,
    parameter int TWR_CYCLES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic       wp_n,
    input  logic [1:0] bp,
    output logic       wel,
    output logic       wip,
    output logic       mem_we,
    output logic [8:0] mem_addr,
    output logic [7:0] mem_wdata
);
    import spiw_pkg::*;

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int CNT_W  = $clog2(TWR_CYCLES + 1);

    generate
        if (TWR_CYCLES < PAGE_BYTES) begin : g_bad_twr
            $error("TWR_CYCLES must cover one page commit");
        end
    endgenerate

    typedef struct packed {
        logic              wel;
        logic              wip;
        logic [CNT_W-1:0]  cnt;
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [OFF_W-1:0]  off;
        logic              got_data;
        logic [PAGE_W-1:0] cpage;
    } eng_st_t;

    eng_st_t q, d;

    logic             cs_fall, cs_rise, byte_stb, wp_ok, prot_hit;
    logic [7:0]       byte_val;
    logic [2:0]       bit_cnt;
    logic             buf_clr, buf_wr, rd_valid;
    logic [7:0]       rd_data;
    logic             write_ok;

    spiw_shift u_shift (
        .clk, .rst_n, .cs_n, .sclk, .mosi, .wp_n,
        .cs_fall, .cs_rise, .byte_stb, .byte_val, .bit_cnt, .wp_ok
    );

    spiw_prot #(.PAGE_W(PAGE_W)) u_prot (
        .bp, .page(q.addr[ADDR_W-1:OFF_W]), .hit(prot_hit)
    );

    spiw_pagebuf #(.DEPTH(PAGE_BYTES)) u_buf (
        .clk, .rst_n, .clr(buf_clr), .wr(buf_wr), .wr_off(q.off),
        .wr_data(byte_val), .rd_off(q.cnt[OFF_W-1:0]),
        .rd_data, .rd_valid
    );

    assign write_ok = q.got_data && (bit_cnt == 3'd0) && q.wel && !q.wip
                      && wp_ok && !prot_hit;

    always_comb begin
        d       = q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;

        if (q.wip) begin
            if (q.cnt == CNT_W'(TWR_CYCLES - 1)) begin
                d.wip = 1'b0;
                d.wel = 1'b0;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (cs_fall) begin
            d.got_data = 1'b0;
            if (q.wip) begin
                d.phase = PH_SKIP;
            end else begin
                d.phase = PH_OPC;
                buf_clr = 1'b1;
            end
        end else if (byte_stb) begin
            unique case (q.phase)
                PH_OPC: begin
                    if (is_write_op(byte_val)) begin
                        d.phase          = PH_ADR;
                        d.addr[ADDR_W-1] = byte_val[3];
                    end else if (byte_val == OP_WREN) begin
                        d.phase = PH_WREN;
                    end else begin
                        d.phase = PH_SKIP;
                    end
                end
                PH_ADR: begin
                    d.addr[7:0] = byte_val;
                    d.off       = byte_val[OFF_W-1:0];
                    d.phase     = PH_DATA;
                end
                PH_DATA: begin
                    buf_wr     = 1'b1;
                    d.off      = q.off + 1'b1;
                    d.got_data = 1'b1;
                end
                PH_WREN: d.phase = PH_SKIP;
                default: ;
            endcase
        end else if (cs_rise) begin
            d.phase = PH_IDLE;
            unique case (q.phase)
                PH_WREN: begin
                    if (bit_cnt == 3'd0 && !q.wip) d.wel = 1'b1;
                end
                PH_ADR, PH_DATA: begin
                    if (write_ok) begin
                        d.wip   = 1'b1;
                        d.cnt   = '0;
                        d.cpage = q.addr[ADDR_W-1:OFF_W];
                    end else begin
                        d.wel = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.wel      <= 1'b0;
            q.wip      <= 1'b0;
            q.cnt      <= '0;
            q.phase    <= PH_IDLE;
            q.addr     <= '0;
            q.off      <= '0;
            q.got_data <= 1'b0;
            q.cpage    <= '0;
        end else begin
            q <= d;
        end
    end

    assign wel       = q.wel;
    assign wip       = q.wip;
    assign mem_we    = q.wip && (q.cnt < CNT_W'(PAGE_BYTES)) && rd_valid;
    assign mem_addr  = {q.cpage, q.cnt[OFF_W-1:0]};
    assign mem_wdata = rd_data;

    a_r9_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wip);
    a_r6_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));
    a_r8_start_needs_wp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wp_ok));
    a_r10_wel_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);
    a_r9_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[8:4] == $past(mem_addr[8:4])));
    a_r11_no_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !u_buf.clr);
endmodule

// File: tb/spiw_write_engine_test.sv
module spiw_write_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int TWR = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic [1:0] bp = 2'b00;
    logic       wel, wip, mem_we;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;

    int checks = 0;
    int fails  = 0;
    int wcount = 0;
    logic [7:0] obs [512];
    logic [7:0] expm [512];

    spiw_write_engine #(.PAGE_BYTES(16), .TWR_CYCLES(TWR)) uut (
        .clk, .rst_n, .cs_n, .sclk, .mosi, .wp_n, .bp,
        .wel, .wip, .mem_we, .mem_addr, .mem_wdata
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (mem_we) begin
            obs[mem_addr] = mem_wdata;
            wcount++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            mosi = v[7-i];
            tick(4);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic desel();
        tick(4);
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic wren();
        sel();
        send_bits(8'h06, 8);
        desel();
    endtask

    function automatic logic [7:0] dval(input int seed, input int k);
        return 8'((seed * 17 + k * 3 + 1) & 255);
    endfunction

    task automatic write_tx(input logic [8:0] a, input int n, input int seed);
        sel();
        send_bits({4'h0, a[8], 3'b010}, 8);
        send_bits(a[7:0], 8);
        for (int k = 0; k < n; k++) send_bits(dval(seed, k), 8);
        desel();
    endtask

    task automatic wait_idle();
        int g = 0;
        while (wip && g < 5000) begin
            tick(1);
            g++;
        end
    endtask

    function automatic logic protected_addr(input logic [1:0] b, input int a);
        return (b == 2'd3) || (b == 2'd2 && a >= 256) || (b == 2'd1 && a >= 384);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int base;
        for (int i = 0; i < 512; i++) begin
            obs[i] = 8'h00;
            expm[i] = 8'h00;
        end
        tick(3);
        // R1 reset state
        chk(wel == 1'b0, "R1 wel", wel, 0);
        chk(wip == 1'b0, "R1 wip", wip, 0);
        chk(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
        rst_n = 1'b1;
        tick(4);

        // R6 write without enable
        write_tx(9'h010, 1, 1);
        chk(wip == 1'b0, "R6 wip stays low", wip, 0);
        tick(20);
        chk(wcount == 0, "R6 no memory write", wcount, 0);

        // R2 enable: nine bits is not a boundary, eight bits is
        sel(); send_bits(8'h06, 8); send_bits(8'h00, 1); desel();
        chk(wel == 1'b0, "R2 off-boundary wren", wel, 0);
        wren();
        chk(wel == 1'b1, "R2 wren sets wel", wel, 1);

        // R3/R9 single byte and cycle timing
        write_tx(9'h005, 1, 7);
        expm[5] = dval(7, 0);
        chk(wip == 1'b1, "R9 wip rises", wip, 1);
        tick(TWR - 12);
        chk(wip == 1'b1, "R9 wip held", wip, 1);
        tick(10);
        chk(wip == 1'b0, "R9 wip falls after cycle", wip, 0);
        chk(obs[5] == expm[5], "R3 byte stored", obs[5], expm[5]);
        chk(wcount == 1, "R3 one write", wcount, 1);
        chk(wel == 1'b0, "R10 wel cleared at end", wel, 0);

        // R4 ninth address bit
        wren();
        write_tx(9'h1F3, 1, 9);
        expm[9'h1F3] = dval(9, 0);
        wait_idle();
        chk(obs[9'h1F3] == expm[9'h1F3], "R4 high address", obs[9'h1F3], expm[9'h1F3]);
        chk(obs[9'h0F3] == 8'h00, "R4 low alias untouched", obs[9'h0F3], 0);

        // R5/R9 every start offset in page 2, 18 bytes to force wrap
        for (int s = 0; s < 16; s++) begin
            base = wcount;
            wren();
            write_tx(9'(32 + s), 18, s + 20);
            for (int k = 0; k < 18; k++) expm[32 + ((s + k) % 16)] = dval(s + 20, k);
            wait_idle();
            for (int o = 0; o < 16; o++)
                chk(obs[32 + o] == expm[32 + o], "R5 page wrap", obs[32 + o], expm[32 + o]);
            chk(wcount - base == 16, "R9 one write per offset", wcount - base, 16);
        end

        // R7 aborts
        base = wcount;
        wren();
        sel(); send_bits(8'h02, 8); send_bits(8'h60, 8); send_bits(8'hAB, 8);
        send_bits(8'hFF, 3); desel();
        chk(wip == 1'b0, "R7 mid-byte deselect", wip, 0);
        chk(wel == 1'b0, "R10 wel cleared on abort", wel, 0);
        wren();
        sel(); send_bits(8'h02, 8); send_bits(8'h61, 8); desel();
        chk(wip == 1'b0, "R7 no data byte", wip, 0);
        tick(20);
        chk(wcount == base, "R7 no write", wcount - base, 0);

        // R8 write-protect pin
        wren();
        wp_n = 1'b0;
        write_tx(9'h070, 1, 3);
        chk(wip == 1'b0, "R8 wp_n low refuses", wip, 0);
        chk(wel == 1'b0, "R10 wel cleared on refusal", wel, 0);
        wp_n = 1'b1;

        // R8 block-protect sweep
        for (int b = 0; b < 4; b++) begin
            for (int p = 0; p < 32; p += 6) begin
                int a;
                a = p * 16 + 9;
                bp = 2'(b);
                base = wcount;
                wren();
                write_tx(9'(a), 1, a);
                wait_idle();
                if (!protected_addr(2'(b), a)) expm[a] = dval(a, 0);
                chk(obs[a] == expm[a], "R8 block protect data", obs[a], expm[a]);
                chk(wcount - base == (protected_addr(2'(b), a) ? 0 : 1),
                    "R8 block protect count", wcount - base,
                    protected_addr(2'(b), a) ? 0 : 1);
            end
        end
        bp = 2'b00;

        // R11 instruction during a running cycle
        wren();
        write_tx(9'h040, 1, 50);
        expm[9'h040] = dval(50, 0);
        base = wcount;
        write_tx(9'h050, 2, 51);
        chk(wip == 1'b1, "R11 still busy", wip, 1);
        wait_idle();
        chk(obs[9'h050] == 8'h00, "R11 ignored write", obs[9'h050], 0);
        chk(obs[9'h040] == expm[9'h040], "R11 first write intact", obs[9'h040], expm[9'h040]);
        chk(wcount - base <= 1, "R11 single commit", wcount - base, 1);
        chk(wel == 1'b0, "R11 wel after cycle", wel, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule